// File: doc/BRIEF.md
# RTC Periodic Interrupt and Square-Wave Generator

This block is the rate-generation slice of a CMOS real-time clock. A host reaches three byte-wide control registers through a small synchronous register port. Register A holds a four-bit rate code in its low nibble, and its upper bits are kept for the oscillator divider settings. Register B holds the enable bits. Register C holds the status flags. A separate tick-enable input pulses once for every cycle of a 32.768 kHz reference. The divider counts only those ticks, so the rate of the block does not depend on the system clock frequency.

The rate code picks a power-of-two tap on the tick counter. That single tap feeds two outputs, and each has its own enable. The periodic interrupt sets two status flags and raises an interrupt line, which stays high until software reads the status register. The square-wave pin toggles at every half period, so its frequency equals the interrupt rate. Codes 1 and 2 fold up onto the slow end of the range. Code 0 stops the timebase completely.

Top module: `rtc_periodic_gen`

## Requirements
- R1: After reset, register A reads 0x26, register B reads 0x02, register C reads 0x00, and both `irq_o` and `sqw_o` are low.
- R2: Registers A (address 0) and B (address 1) read back exactly what was written, including B bits 5, 4 and 2. Those three bits have no effect on `irq_o` or `sqw_o`.
- R3: The effective code is the rate code plus 7 when the rate code is 1 or 2, and the rate code itself for codes 3 to 15. The period is 2^(effective code − 1) cycles in which `tick_i` is high. Cycles with `tick_i` low are not counted.
- R4: The timebase runs only when the rate code is nonzero and at least one of B bit 6 (periodic interrupt enable) or B bit 3 (square-wave enable) is set. With rate code 0, `irq_o` and `sqw_o` stay low.
- R5: Each period expiry while B bit 6 is set sets C bit 7 and C bit 6, so C reads 0xC0. `irq_o` follows C bit 7.
- R6: While B bit 3 is set and the rate code is nonzero, `sqw_o` starts low and toggles after every half period. This means it is high in the second half-period and falls at each expiry. The square wave leaves register C untouched when B bit 6 is clear. `sqw_o` is held low whenever B bit 3 is clear.
- R7: A read of C (address 2) returns its current value and then clears it, which drops `irq_o`. Writes to C are ignored. Address 3 reads 0x00.
- R8: Any write to register A restarts the divider from zero, so the next expiry occurs a full period after the write.
- R9: When an expiry with B bit 6 set coincides with a read of C, the read returns the old value and the flags remain set afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle enable per 32.768 kHz reference cycle |
| acc_en_i | input | 1 | Register access strobe |
| acc_we_i | input | 1 | 1 = write, 0 = read |
| acc_addr_i | input | 2 | Register select: 0 = A, 1 = B, 2 = C, 3 = unused |
| acc_wdata_i | input | 8 | Write data |
| acc_rdata_o | output | 8 | Read data for the addressed register (combinational) |
| irq_o | output | 1 | Periodic interrupt request |
| sqw_o | output | 1 | Square-wave output |

## Verification
The bound checker watches these rules on every cycle:
- an expiry with the interrupt enable set raises the interrupt, even when a status read happens in the same cycle;
- a status read clears the flags, and a status write leaves them unchanged;
- a write to register A returns the counter to zero;
- the interrupt and the square wave rise only on a reference tick;
- the square wave goes low whenever its enable is clear.

Only the bench scenarios can show the exact period for each rate code and the folding of codes 1 and 2. They also show the half-period phase of the square wave, the lack of any effect from the stored alarm, update and data-mode bits, and the register reset values.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef enum logic [1:0] {
    RSEL_RATE   = 2'd0,
    RSEL_ENABLE = 2'd1,
    RSEL_STATUS = 2'd2,
    RSEL_NONE   = 2'd3
  } rsel_e;

  // enable register bit positions
  localparam int unsigned EN_PERIODIC_BIT = 6;
  localparam int unsigned EN_SQUARE_BIT   = 3;

  // status register bit positions
  localparam int unsigned ST_REQ_BIT    = 7;
  localparam int unsigned ST_PERIOD_BIT = 6;

  localparam logic [7:0] RATE_REG_RST   = 8'h26;
  localparam logic [7:0] ENABLE_REG_RST = 8'h02;
  localparam logic [7:0] STATUS_REG_RST = 8'h00;
  localparam logic [7:0] STATUS_SET_MASK =
    (8'h01 << ST_REQ_BIT) | (8'h01 << ST_PERIOD_BIT);

endpackage

// File: rtl/rtc_ctrl_regs.sv
module rtc_ctrl_regs
  import rtc_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              acc_we,
  input  logic [1:0]        acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] acc_rdata,
  input  logic              expire,
  output logic [DATA_W-1:0] rate_reg,
  output logic [DATA_W-1:0] enable_reg,
  output logic [DATA_W-1:0] status_reg,
  output logic              wr_rate,
  output logic              rd_status,
  output logic              wr_status
);

  rsel_e             sel;
  logic              wr_enable;
  logic              set_flags;
  logic [DATA_W-1:0] rate_q, rate_d;
  logic [DATA_W-1:0] enable_q, enable_d;
  logic [DATA_W-1:0] status_q, status_d;

  // access decode
  always_comb begin
    sel       = rsel_e'(acc_addr);
    wr_rate   = acc_en && acc_we  && (sel == RSEL_RATE);
    wr_enable = acc_en && acc_we  && (sel == RSEL_ENABLE);
    wr_status = acc_en && acc_we  && (sel == RSEL_STATUS);
    rd_status = acc_en && !acc_we && (sel == RSEL_STATUS);
    set_flags = expire && enable_q[EN_PERIODIC_BIT];
  end

  // next state
  always_comb begin
    rate_d   = rate_q;
    enable_d = enable_q;
    status_d = status_q;
    if (wr_rate)   rate_d   = acc_wdata;
    if (wr_enable) enable_d = acc_wdata;
    // status ignores writes; read clears; a new event wins over the clear
    if (rd_status) status_d = '0;
    if (set_flags) status_d = status_d | DATA_W'(STATUS_SET_MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q   <= DATA_W'(RATE_REG_RST);
      enable_q <= DATA_W'(ENABLE_REG_RST);
      status_q <= DATA_W'(STATUS_REG_RST);
    end else begin
      rate_q   <= rate_d;
      enable_q <= enable_d;
      status_q <= status_d;
    end
  end

  // read mux
  always_comb begin
    unique case (sel)
      RSEL_RATE:   acc_rdata = rate_q;
      RSEL_ENABLE: acc_rdata = enable_q;
      RSEL_STATUS: acc_rdata = status_q;
      default:     acc_rdata = '0;
    endcase
  end

  assign rate_reg   = rate_q;
  assign enable_reg = enable_q;
  assign status_reg = status_q;

endmodule

// File: rtl/rtc_rate_div.sv
module rtc_rate_div #(
  parameter int unsigned RATE_W = 4,
  parameter int unsigned DIV_W  = (1 << RATE_W) - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [RATE_W-1:0] rate,
  input  logic              run,
  input  logic              restart,
  output logic              half_evt,
  output logic              full_evt,
  output logic [DIV_W-1:0]  cnt_o
);

  logic [RATE_W-1:0] rate_eff;
  logic [DIV_W:0]    one_hot_period;
  logic [DIV_W-1:0]  period_m1;
  logic [DIV_W-1:0]  half_m1;
  logic [DIV_W-1:0]  cnt_q, cnt_d;
  logic              step;

  // fold the two fastest codes onto the slow end, then form the tap limits
  always_comb begin
    if ((rate != '0) && (rate <= RATE_W'(2))) rate_eff = rate + RATE_W'(7);
    else                                      rate_eff = rate;
    one_hot_period = {{DIV_W{1'b0}}, 1'b1} << (rate_eff - RATE_W'(1));
    period_m1      = one_hot_period[DIV_W-1:0] - DIV_W'(1);
    half_m1        = one_hot_period[DIV_W:1] - DIV_W'(1);
  end

  always_comb begin
    step     = tick && run && !restart;
    full_evt = step && (cnt_q == period_m1);
    half_evt = step && (cnt_q == half_m1);
    cnt_d    = cnt_q;
    if (restart || !run) cnt_d = '0;
    else if (full_evt)   cnt_d = '0;
    else if (step)       cnt_d = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/rtc_sqw_out.sv
module rtc_sqw_out (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic restart,
  input  logic half_evt,
  input  logic full_evt,
  output logic sqw
);

  logic sqw_q, sqw_d;

  always_comb begin
    sqw_d = sqw_q;
    if (!en || restart)         sqw_d = 1'b0;
    else if (half_evt || full_evt) sqw_d = !sqw_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sqw_q <= 1'b0;
    else        sqw_q <= sqw_d;
  end

  assign sqw = sqw_q;

endmodule

// File: rtl/rtc_periodic_gen.sv
module rtc_periodic_gen
  import rtc_pkg::*;
#(
  parameter int unsigned RATE_W = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              acc_en_i,
  input  logic              acc_we_i,
  input  logic [1:0]        acc_addr_i,
  input  logic [DATA_W-1:0] acc_wdata_i,
  output logic [DATA_W-1:0] acc_rdata_o,
  output logic              irq_o,
  output logic              sqw_o
);

  localparam int unsigned DIV_W = (1 << RATE_W) - 2;

  logic              rst_meta_q, rst_sync_q;
  logic [DATA_W-1:0] rate_reg, enable_reg, status_reg;
  logic              wr_rate, rd_status, wr_status;
  logic [RATE_W-1:0] rate_code;
  logic              pie, sqwe, run, sqw_en;
  logic              half_evt, full_evt;
  logic [DIV_W-1:0]  cnt;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  rtc_ctrl_regs #(.DATA_W(DATA_W)) u_regs (
    .clk        (clk_i),
    .rst_n      (rst_sync_q),
    .acc_en     (acc_en_i),
    .acc_we     (acc_we_i),
    .acc_addr   (acc_addr_i),
    .acc_wdata  (acc_wdata_i),
    .acc_rdata  (acc_rdata_o),
    .expire     (full_evt),
    .rate_reg   (rate_reg),
    .enable_reg (enable_reg),
    .status_reg (status_reg),
    .wr_rate    (wr_rate),
    .rd_status  (rd_status),
    .wr_status  (wr_status)
  );

  always_comb begin
    rate_code = rate_reg[RATE_W-1:0];
    pie       = enable_reg[EN_PERIODIC_BIT];
    sqwe      = enable_reg[EN_SQUARE_BIT];
    run       = (rate_code != '0) && (pie || sqwe);
    sqw_en    = (rate_code != '0) && sqwe;
  end

  rtc_rate_div #(.RATE_W(RATE_W), .DIV_W(DIV_W)) u_div (
    .clk      (clk_i),
    .rst_n    (rst_sync_q),
    .tick     (tick_i),
    .rate     (rate_code),
    .run      (run),
    .restart  (wr_rate),
    .half_evt (half_evt),
    .full_evt (full_evt),
    .cnt_o    (cnt)
  );

  rtc_sqw_out u_sqw (
    .clk      (clk_i),
    .rst_n    (rst_sync_q),
    .en       (sqw_en),
    .restart  (wr_rate),
    .half_evt (half_evt),
    .full_evt (full_evt),
    .sqw      (sqw_o)
  );

  assign irq_o = status_reg[ST_REQ_BIT];

endmodule

// File: rtl/rtc_periodic_chk.sv
module rtc_periodic_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DIV_W  = 14
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              irq_o,
  input logic              sqw_o,
  input logic              wr_rate,
  input logic              rd_status,
  input logic              wr_status,
  input logic              full_evt,
  input logic              pie,
  input logic              sqw_en,
  input logic [DIV_W-1:0]  cnt,
  input logic [DATA_W-1:0] status_reg
);

  // R9: expiry with interrupt enabled always leaves the request raised
  assert_expire_raises_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_evt && pie) |=> irq_o);

  // R7: a status read with no coinciding event empties the status register
  assert_read_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_status && !(full_evt && pie)) |=> (status_reg == '0));

  // R7: a status write changes nothing
  assert_write_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_status && !(full_evt && pie)) |=> $stable(status_reg));

  // R8: rate register write returns the divider to zero
  assert_restart_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_rate |=> (cnt == '0));

  // R5: the request only rises on a reference tick
  assert_irq_on_tick_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(tick_i));

  // R6: the square wave only rises on a reference tick
  assert_sqw_on_tick_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sqw_o) |-> $past(tick_i));

  // R4: square wave held low while disabled
  assert_sqw_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sqw_en |=> !sqw_o);

endmodule

bind rtc_periodic_gen rtc_periodic_chk #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .irq_o      (irq_o),
  .sqw_o      (sqw_o),
  .wr_rate    (wr_rate),
  .rd_status  (rd_status),
  .wr_status  (wr_status),
  .full_evt   (full_evt),
  .pie        (pie),
  .sqw_en     (sqw_en),
  .cnt        (cnt),
  .status_reg (status_reg)
);

// File: tb/rtc_periodic_gen_bench.sv
module rtc_periodic_gen_bench;

  logic       clk;
  logic       rst_n;
  logic       tick;
  logic       en, we;
  logic [1:0] addr;
  logic [7:0] wdata, rdata;
  logic       irq, sqw;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  rtc_periodic_gen u_rtc_periodic_gen (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .tick_i      (tick),
    .acc_en_i    (en),
    .acc_we_i    (we),
    .acc_addr_i  (addr),
    .acc_wdata_i (wdata),
    .acc_rdata_o (rdata),
    .irq_o       (irq),
    .sqw_o       (sqw)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic [3:0]  rate;
    logic [7:0]  enb;
    logic [15:0] nticks;
    logic        exp_irq;
    logic        exp_sqw;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{4'd3,  8'h40, 16'd3,     1'b0, 1'b0},  // R3 one short of period 4
    '{4'd3,  8'h40, 16'd4,     1'b1, 1'b0},  // R5 expiry
    '{4'd3,  8'h08, 16'd2,     1'b0, 1'b1},  // R6 half period high
    '{4'd3,  8'h08, 16'd4,     1'b0, 1'b0},  // R6 falls at expiry
    '{4'd3,  8'h08, 16'd3,     1'b0, 1'b1},  // R6
    '{4'd6,  8'h40, 16'd31,    1'b0, 1'b0},  // R3 code 6 -> 32
    '{4'd6,  8'h40, 16'd32,    1'b1, 1'b0},  // R3
    '{4'd1,  8'h40, 16'd127,   1'b0, 1'b0},  // R3 code 1 folds to 8 -> 128
    '{4'd1,  8'h40, 16'd128,   1'b1, 1'b0},  // R3
    '{4'd2,  8'h48, 16'd255,   1'b0, 1'b1},  // R3 code 2 folds to 9 -> 256
    '{4'd2,  8'h48, 16'd256,   1'b1, 1'b0},  // R5 R6 both enabled
    '{4'd0,  8'h48, 16'd300,   1'b0, 1'b0},  // R4 code 0 stops
    '{4'd5,  8'h00, 16'd20,    1'b0, 1'b0},  // R4 both enables clear
    '{4'd5,  8'h34, 16'd16,    1'b0, 1'b0},  // R2 stored bits inert
    '{4'd4,  8'h08, 16'd12,    1'b0, 1'b1},  // R6 period 8, third half
    '{4'd15, 8'h40, 16'd16384, 1'b1, 1'b0}   // R3 slowest code
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    en = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    en = 1'b0; we = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    en = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    en = 1'b0;
  endtask

  task automatic run_ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    tick = 0; en = 0; we = 0; addr = 0; wdata = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    reg_rd(2'd0, d); check("R1 reg A", 16'(d), 16'h26);
    reg_rd(2'd1, d); check("R1 reg B", 16'(d), 16'h02);
    reg_rd(2'd2, d); check("R1 reg C", 16'(d), 16'h00);
    check("R1 irq", 16'(irq), 16'h0);
    check("R1 sqw", 16'(sqw), 16'h0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      reg_wr(2'd1, VECS[i].enb);
      reg_wr(2'd0, {4'h2, VECS[i].rate});
      reg_rd(2'd2, d);
      run_ticks(int'(VECS[i].nticks));
      check($sformatf("R3/R5 vec%0d irq", i), 16'(irq), 16'(VECS[i].exp_irq));
      check($sformatf("R6/R4 vec%0d sqw", i), 16'(sqw), 16'(VECS[i].exp_sqw));
      reg_rd(2'd2, d);
      check($sformatf("R5/R7 vec%0d status", i), 16'(d),
            VECS[i].exp_irq ? 16'hC0 : 16'h00);
      check($sformatf("R7 vec%0d irq after read", i), 16'(irq), 16'h0);
    end

    // R2 readback of stored enable bits
    reg_wr(2'd1, 8'h34);
    reg_rd(2'd1, d); check("R2 reg B readback", 16'(d), 16'h34);
    reg_wr(2'd0, 8'h5A);
    reg_rd(2'd0, d); check("R2 reg A readback", 16'(d), 16'h5A);

    // R7 writes to C ignored, address 3 reads zero
    reg_wr(2'd2, 8'hFF);
    reg_rd(2'd2, d); check("R7 C write ignored", 16'(d), 16'h00);
    reg_rd(2'd3, d); check("R7 addr3 reads zero", 16'(d), 16'h00);

    // R3 spaced ticks: idle cycles are not counted
    reg_wr(2'd1, 8'h40);
    reg_wr(2'd0, 8'h23);
    reg_rd(2'd2, d);
    for (int k = 0; k < 3; k++) begin
      run_ticks(1);
      repeat (5) @(negedge clk);
    end
    check("R3 spaced ticks before period", 16'(irq), 16'h0);
    run_ticks(1);
    check("R3 spaced ticks at period", 16'(irq), 16'h1);
    reg_rd(2'd2, d);

    // R8 rewrite of A restarts the divider
    run_ticks(3);
    reg_wr(2'd0, 8'h23);
    run_ticks(3);
    check("R8 no expiry after restart", 16'(irq), 16'h0);
    run_ticks(1);
    check("R8 expiry full period after restart", 16'(irq), 16'h1);
    reg_rd(2'd2, d);

    // R9 expiry coincides with a status read
    reg_wr(2'd0, 8'h23);
    reg_rd(2'd2, d);
    run_ticks(3);
    @(negedge clk);
    tick = 1'b1; en = 1'b1; we = 1'b0; addr = 2'd2;
    #1 d = rdata;
    @(negedge clk);
    tick = 1'b0; en = 1'b0;
    check("R9 read returns old value", 16'(d), 16'h00);
    check("R9 irq stays set", 16'(irq), 16'h1);
    reg_rd(2'd2, d);
    check("R9 flags kept", 16'(d), 16'hC0);

    // R6 clearing the square-wave enable forces the pin low
    reg_wr(2'd1, 8'h08);
    reg_wr(2'd0, 8'h23);
    run_ticks(2);
    check("R6 sqw high mid-period", 16'(sqw), 16'h1);
    reg_wr(2'd1, 8'h00);
    @(negedge clk);
    check("R6 sqw low when disabled", 16'(sqw), 16'h0);

    finish_run();
  end

endmodule